// File: doc/BRIEF.md
# Bus Cycle Status Encoder with Reset Straps

This block drives the three status pins of a 16-bit processor bus interface that name the kind of bus cycle in progress, plus a fourth status pin that marks DMA-initiated cycles. The bus sequencer supplies the cycle kind, the current T-state and a DMA flag. The block registers a status code and turns it into a pin value and an output enable. Hold, hold acknowledge and the on-circuit-emulation mode float the pins. No tri-state nets are used: each pin is a value, an enable and a sampled input.

The same pins serve as configuration inputs while reset is held. External pull-ups keep them high, and a board asserts a strap by pulling its pin low. On the first clock edge that sees reset released, the block latches four straps: internal memory disable, show-read enable and two clock-select bits. These stay fixed until the next reset. When show-read is latched and internal memory is enabled, reads from internal memory drive every lane of the address/data bus during the data phases.

A pin-mode state machine decides who owns the pins. Its states are `PM_STRAP` (reset: pins are inputs), `PM_DRIVE` (status and DMA pins driven), `PM_ONCE` (emulation: status floated, DMA pin driven) and `PM_HOLD` (bus granted away: all pins floated). Reset forces `PM_STRAP` from any state. Every other transition is taken on each clock: hold or hold acknowledge leads to `PM_HOLD`, and this takes priority. Otherwise the emulation mode input leads to `PM_ONCE`, and with neither of them the machine goes to `PM_DRIVE`. Leaving `PM_STRAP` is the strap capture edge.

Top module: `bus_status_strap`

## Requirements
- R1: One clock after the sequencer presents T1, T2 or T3, the status value shows the cycle kind as follows. The cycle kind input codes are 0 none, 1 instruction fetch, 2 memory read, 3 memory write, 4 I/O read, 5 I/O write, 6 interrupt acknowledge and 7 halt. The matching status codes are 111, 100, 101, 110, 001, 010, 000 and 011. Bit 2 is 1 for memory cycles and 0 for I/O cycles. Bit 1 marks a transmit.
- R2: One clock after an idle, T4 or unused T-state (T-state codes 0 idle, 1 T1, 2 T2, 3 T3, 4 T4; 5 to 7 count as idle), the status value is the passive code 111.
- R3: One clock after hold, hold acknowledge or emulation mode is seen, all three status enables are low. One clock after hold or hold acknowledge, the DMA pin enable is low. In emulation mode without hold, the DMA pin stays driven.
- R4: One clock after a T-state of T2, T3 or T4 with the DMA flag set, the DMA pin value is 1. After T1, idle, or any cycle without the flag, it is 0.
- R5: While reset is held, every pin enable and both show-read lane enables are low. The latched configuration reads its defaults: no memory disable, no show-read, clock selects 11.
- R6: The straps are sampled on the first clock edge with reset released. A low status pin 1 sets memory disable. A low status pin 0 sets show-read. Low on the DMA pin or on the separate clock-select-2 pin gives a 0 in clock-select bit 0 or bit 1. The captured values stay unchanged until reset is asserted again, whatever the pins do later.
- R7: With both clock-select straps left high, the latched select reads 11 and the times-four flag is 1. Any other select value clears the flag.
- R8: One clock after a T2 or T3 of a fetch or memory read that targets internal memory, all lane enables of the show-read output are 1. This holds only when show-read is latched, memory disable is not latched and the pin mode goes to `PM_DRIVE`. In every other case the lane enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps latch on its release |
| cyc_type | input | 3 | Cycle kind code from the bus sequencer |
| tstate | input | 3 | Current T-state code |
| dma_cyc | input | 1 | Current cycle was started by DMA |
| imem_rd | input | 1 | Current read targets internal memory |
| hold | input | 1 | Bus hold requested |
| hlda | input | 1 | Bus hold acknowledged |
| once_mode | input | 1 | On-circuit-emulation mode active |
| stat_o | output | 3 | Status pin values |
| stat_oe | output | 3 | Status pin output enables |
| dma_o | output | 1 | DMA status pin value |
| dma_oe | output | 1 | DMA status pin output enable |
| pin_s1_in | input | 1 | Sampled level of status pin 1 (memory-disable strap) |
| pin_s0_in | input | 1 | Sampled level of status pin 0 (show-read strap) |
| pin_dma_in | input | 1 | Sampled level of DMA pin (clock-select bit 0 strap) |
| pin_cs2_in | input | 1 | Sampled level of the clock-select bit 1 strap pin |
| cfg_imdis | output | 1 | Latched internal memory disable |
| cfg_sren | output | 1 | Latched show-read enable |
| cfg_clksel | output | 2 | Latched clock-select straps |
| cfg_clk_x4 | output | 1 | Latched clock mode is times four |
| show_lane_oe | output | LANES | Per-lane show-read drive enables |

## Verification
The assertions assume a sequencer that only presents defined cycle kinds, and T-states that the block can treat as idle when unused. They also assume that the strap pins are real pulled-up levels, and that reset is synchronous and held for at least one clock. The stimulus keeps to this: the bench models each pin as the design's value when enabled and otherwise as a pull-up or an external low, and it holds reset for two clocks before every release. Only strap drivers are changed during reset. All other inputs change between clock edges.

// File: rtl/bss_pkg.sv
package bss_pkg;

    localparam int ST_W = 3;

    typedef enum logic [2:0] {
        CY_NONE  = 3'd0,
        CY_FETCH = 3'd1,
        CY_MEMRD = 3'd2,
        CY_MEMWR = 3'd3,
        CY_IORD  = 3'd4,
        CY_IOWR  = 3'd5,
        CY_INTA  = 3'd6,
        CY_HALT  = 3'd7
    } cyc_e;

    localparam logic [2:0] TS_IDLE = 3'd0;
    localparam logic [2:0] TS_T1   = 3'd1;
    localparam logic [2:0] TS_T2   = 3'd2;
    localparam logic [2:0] TS_T3   = 3'd3;
    localparam logic [2:0] TS_T4   = 3'd4;

    typedef enum logic [1:0] {
        PM_STRAP = 2'd0,
        PM_DRIVE = 2'd1,
        PM_ONCE  = 2'd2,
        PM_HOLD  = 2'd3
    } pmode_e;

    localparam logic [ST_W-1:0] STC_PASSIVE = 3'b111;

    typedef struct packed {
        logic       imdis;
        logic       sren;
        logic [1:0] clksel;
    } strap_t;

    localparam strap_t STRAP_DEFAULT = '{imdis: 1'b0, sren: 1'b0, clksel: 2'b11};

endpackage

// File: rtl/bss_encoder.sv
module bss_encoder
    import bss_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      cyc_type,
    input  logic [2:0]      tstate,
    input  logic            dma_cyc,
    output logic [ST_W-1:0] code_q,
    output logic            dma_q
);

    cyc_e            cyc;
    logic            addr_data_phase;
    logic            dma_window;
    logic [ST_W-1:0] kind_code;
    logic [ST_W-1:0] code_nxt;

    assign cyc = cyc_e'(cyc_type);

    always_comb begin
        addr_data_phase = (tstate == TS_T1) || (tstate == TS_T2) || (tstate == TS_T3);
        dma_window      = (tstate == TS_T2) || (tstate == TS_T3) || (tstate == TS_T4);
    end

    // Bit 2 separates memory from I/O, bit 1 marks a transmit.
    always_comb begin
        unique case (cyc)
            CY_NONE:  kind_code = STC_PASSIVE;
            CY_FETCH: kind_code = 3'b100;
            CY_MEMRD: kind_code = 3'b101;
            CY_MEMWR: kind_code = 3'b110;
            CY_IORD:  kind_code = 3'b001;
            CY_IOWR:  kind_code = 3'b010;
            CY_INTA:  kind_code = 3'b000;
            CY_HALT:  kind_code = 3'b011;
        endcase
        code_nxt = addr_data_phase ? kind_code : STC_PASSIVE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= STC_PASSIVE;
            dma_q  <= 1'b0;
        end else begin
            code_q <= code_nxt;
            dma_q  <= dma_cyc && dma_window;
        end
    end

    p_mem_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((tstate == TS_T2) && ((cyc_type == 3'd1) || (cyc_type == 3'd2) || (cyc_type == 3'd3)))
        |=> code_q[2]);

    p_passive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((tstate == TS_IDLE) || (tstate == TS_T4)) |=> (code_q == 3'b111));

    p_dma_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_cyc && (tstate == TS_T3)) |=> dma_q);

    p_dma_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((tstate == TS_T1) || (tstate == TS_IDLE) || !dma_cyc) |=> !dma_q);

endmodule

// File: rtl/bss_pin_fsm.sv
module bss_pin_fsm
    import bss_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            hlda,
    input  logic            once_mode,
    output pmode_e          mode_q,
    output pmode_e          mode_nxt,
    output logic            capture,
    output logic [ST_W-1:0] stat_oe,
    output logic            dma_oe
);

    logic float_req;

    assign float_req = hold || hlda;

    always_comb begin
        unique case (mode_q)
            PM_STRAP: begin
                if (float_req)      mode_nxt = PM_HOLD;
                else if (once_mode) mode_nxt = PM_ONCE;
                else                mode_nxt = PM_DRIVE;
            end
            PM_DRIVE: begin
                if (float_req)      mode_nxt = PM_HOLD;
                else if (once_mode) mode_nxt = PM_ONCE;
                else                mode_nxt = PM_DRIVE;
            end
            PM_ONCE: begin
                if (float_req)       mode_nxt = PM_HOLD;
                else if (!once_mode) mode_nxt = PM_DRIVE;
                else                 mode_nxt = PM_ONCE;
            end
            PM_HOLD: begin
                if (float_req)      mode_nxt = PM_HOLD;
                else if (once_mode) mode_nxt = PM_ONCE;
                else                mode_nxt = PM_DRIVE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= PM_STRAP;
        else        mode_q <= mode_nxt;
    end

    always_comb begin
        capture = (mode_q == PM_STRAP) && rst_n;
        stat_oe = {ST_W{mode_q == PM_DRIVE}};
        dma_oe  = (mode_q == PM_DRIVE) || (mode_q == PM_ONCE);
    end

    p_float_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold || hlda) |=> ((stat_oe == '0) && !dma_oe));

    p_float_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (once_mode && !hold && !hlda) |=> ((stat_oe == '0) && dma_oe));

    p_strap_leave_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_STRAP) |=> (mode_q != PM_STRAP));

endmodule

// File: rtl/bss_strap_latch.sv
module bss_strap_latch
    import bss_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   capture,
    input  logic   pin_s1_in,
    input  logic   pin_s0_in,
    input  logic   pin_dma_in,
    input  logic   pin_cs2_in,
    output strap_t cfg_q
);

    strap_t sampled;

    // Straps are asserted by pulling the pin low against its pull-up.
    always_comb begin
        sampled.imdis  = !pin_s1_in;
        sampled.sren   = !pin_s0_in;
        sampled.clksel = {pin_cs2_in, pin_dma_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= STRAP_DEFAULT;
        else if (capture) cfg_q <= sampled;
    end

    p_strap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(cfg_q));

endmodule

// File: rtl/bss_show_gate.sv
module bss_show_gate
    import bss_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  strap_t           cfg,
    input  pmode_e           mode_nxt,
    input  logic [2:0]       cyc_type,
    input  logic [2:0]       tstate,
    input  logic             imem_rd,
    output logic [LANES-1:0] lane_oe
);

    logic is_read;
    logic data_phase;
    logic want;

    always_comb begin
        is_read    = (cyc_e'(cyc_type) == CY_MEMRD) || (cyc_e'(cyc_type) == CY_FETCH);
        data_phase = (tstate == TS_T2) || (tstate == TS_T3);
        want       = cfg.sren && !cfg.imdis && imem_rd && is_read && data_phase
                     && (mode_nxt == PM_DRIVE);
    end

    // Every lane is driven, whatever the width of the read.
    always_ff @(posedge clk) begin
        if (!rst_n) lane_oe <= '0;
        else        lane_oe <= {LANES{want}};
    end

    p_show_all_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lane_oe) == 0) || ($countones(lane_oe) == LANES));

    p_show_needs_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_oe != '0) |-> (cfg.sren && !cfg.imdis));

endmodule

// File: rtl/bus_status_strap.sv
module bus_status_strap
    import bss_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cyc_type,
    input  logic [2:0]       tstate,
    input  logic             dma_cyc,
    input  logic             imem_rd,
    input  logic             hold,
    input  logic             hlda,
    input  logic             once_mode,
    output logic [2:0]       stat_o,
    output logic [2:0]       stat_oe,
    output logic             dma_o,
    output logic             dma_oe,
    input  logic             pin_s1_in,
    input  logic             pin_s0_in,
    input  logic             pin_dma_in,
    input  logic             pin_cs2_in,
    output logic             cfg_imdis,
    output logic             cfg_sren,
    output logic [1:0]       cfg_clksel,
    output logic             cfg_clk_x4,
    output logic [LANES-1:0] show_lane_oe
);

    pmode_e          mode_q;
    pmode_e          mode_nxt;
    logic            capture;
    logic [ST_W-1:0] code_q;
    logic            dma_q;
    strap_t          cfg_q;

    bss_encoder u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_type (cyc_type),
        .tstate   (tstate),
        .dma_cyc  (dma_cyc),
        .code_q   (code_q),
        .dma_q    (dma_q)
    );

    bss_pin_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .hlda      (hlda),
        .once_mode (once_mode),
        .mode_q    (mode_q),
        .mode_nxt  (mode_nxt),
        .capture   (capture),
        .stat_oe   (stat_oe),
        .dma_oe    (dma_oe)
    );

    bss_strap_latch u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .pin_s1_in  (pin_s1_in),
        .pin_s0_in  (pin_s0_in),
        .pin_dma_in (pin_dma_in),
        .pin_cs2_in (pin_cs2_in),
        .cfg_q      (cfg_q)
    );

    bss_show_gate #(.LANES(LANES)) u_show (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg_q),
        .mode_nxt (mode_nxt),
        .cyc_type (cyc_type),
        .tstate   (tstate),
        .imem_rd  (imem_rd),
        .lane_oe  (show_lane_oe)
    );

    always_comb begin
        stat_o     = code_q;
        dma_o      = dma_q;
        cfg_imdis  = cfg_q.imdis;
        cfg_sren   = cfg_q.sren;
        cfg_clksel = cfg_q.clksel;
        cfg_clk_x4 = (cfg_q.clksel == 2'b11);
    end

    p_memrd_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((tstate == TS_T1) && (cyc_type == 3'd2)) |=> (stat_o == 3'b101));

    p_x4_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && pin_dma_in && pin_cs2_in) |=> cfg_clk_x4);

endmodule

// File: tb/bus_status_strap_bench.sv
`timescale 1ns/1ps
module bus_status_strap_bench;

    localparam int LANES = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cyc_type = 3'd0;
    logic [2:0] tstate = 3'd0;
    logic dma_cyc = 1'b0, imem_rd = 1'b0, hold = 1'b0, hlda = 1'b0, once_mode = 1'b0;
    logic [2:0] stat_o, stat_oe;
    logic dma_o, dma_oe;
    logic cfg_imdis, cfg_sren, cfg_clk_x4;
    logic [1:0] cfg_clksel;
    logic [LANES-1:0] show_lane_oe;
    logic [3:0] ext_low = 4'd0;   // bit0 s1, bit1 s0, bit2 dma pin, bit3 cs2 pin
    logic pin_s1, pin_s0, pin_dma, pin_cs2;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Pull-up pin model: design drive wins, else external low, else high.
    assign pin_s1  = stat_oe[1] ? stat_o[1] : !ext_low[0];
    assign pin_s0  = stat_oe[0] ? stat_o[0] : !ext_low[1];
    assign pin_dma = dma_oe ? dma_o : !ext_low[2];
    assign pin_cs2 = !ext_low[3];

    bus_status_strap #(.LANES(LANES)) u_bus_status_strap (
        .clk(clk), .rst_n(rst_n), .cyc_type(cyc_type), .tstate(tstate),
        .dma_cyc(dma_cyc), .imem_rd(imem_rd), .hold(hold), .hlda(hlda),
        .once_mode(once_mode), .stat_o(stat_o), .stat_oe(stat_oe),
        .dma_o(dma_o), .dma_oe(dma_oe), .pin_s1_in(pin_s1), .pin_s0_in(pin_s0),
        .pin_dma_in(pin_dma), .pin_cs2_in(pin_cs2), .cfg_imdis(cfg_imdis),
        .cfg_sren(cfg_sren), .cfg_clksel(cfg_clksel), .cfg_clk_x4(cfg_clk_x4),
        .show_lane_oe(show_lane_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int exp_code(input int c, input int t);
        if (t < 1 || t > 3) return 7;
        case (c)
            1: return 4; 2: return 5; 3: return 6; 4: return 1;
            5: return 2; 6: return 0; 7: return 3; default: return 7;
        endcase
    endfunction

    task automatic do_reset(input logic [3:0] straps);
        rst_n = 1'b0;
        ext_low = straps;
        step();
        step();
        rst_n = 1'b1;
        step();
        ext_low = 4'd0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1;
        // R5: state during reset, with straps being driven
        ext_low = 4'b1111;
        step();
        step();
        chk("R5 stat_oe in reset", stat_oe, 0);
        chk("R5 dma_oe in reset", dma_oe, 0);
        chk("R5 show lanes in reset", show_lane_oe, 0);
        chk("R5 default imdis", cfg_imdis, 0);
        chk("R5 default sren", cfg_sren, 0);
        chk("R5 default clksel", cfg_clksel, 3);
        rst_n = 1'b1;
        step();
        ext_low = 4'd0;
        chk("R6 capture imdis", cfg_imdis, 1);
        chk("R6 capture clksel", cfg_clksel, 0);
        chk("R7 x4 cleared", cfg_clk_x4, 0);

        do_reset(4'd0);
        chk("R7 default clksel", cfg_clksel, 3);
        chk("R7 default x4", cfg_clk_x4, 1);

        // R1 R2 R4: full sweep of cycle kind, T-state and DMA flag
        for (int c = 0; c < 8; c++)
            for (int t = 0; t < 8; t++)
                for (int d = 0; d < 2; d++) begin
                    cyc_type = 3'(c);
                    tstate = 3'(t);
                    dma_cyc = d[0];
                    step();
                    if (t >= 1 && t <= 3) chk("R1 status code", stat_o, exp_code(c, t));
                    else chk("R2 passive code", stat_o, 7);
                    chk("R1 status driven", stat_oe, 7);
                    chk("R4 dma value", dma_o, (d == 1 && t >= 2 && t <= 4) ? 1 : 0);
                    chk("R4 dma driven", dma_oe, 1);
                end

        // R3: float sweep over hold, hold ack, emulation
        cyc_type = 3'd2;
        tstate = 3'd2;
        dma_cyc = 1'b1;
        for (int f = 0; f < 8; f++) begin
            hold = f[0];
            hlda = f[1];
            once_mode = f[2];
            step();
            chk("R3 status enables", stat_oe, (f != 0) ? 0 : 7);
            chk("R3 dma enable", dma_oe, (f[0] || f[1]) ? 0 : 1);
        end
        hold = 1'b0;
        hlda = 1'b0;
        once_mode = 1'b0;
        step();
        chk("R3 drive resumes", stat_oe, 7);

        // R6 R7: every strap combination, then pins toggle after capture
        for (int s = 0; s < 16; s++) begin
            do_reset(4'(s));
            chk("R6 imdis strap", cfg_imdis, s[0]);
            chk("R6 sren strap", cfg_sren, s[1]);
            chk("R6 clksel strap", cfg_clksel, {!s[3], !s[2]});
            chk("R7 x4 flag", cfg_clk_x4, (!s[2] && !s[3]) ? 1 : 0);
            cyc_type = 3'd5;
            dma_cyc = 1'b1;
            for (int t = 1; t < 5; t++) begin
                tstate = 3'(t);
                ext_low = 4'(15 - s);
                step();
            end
            ext_low = 4'd0;
            dma_cyc = 1'b0;
            tstate = 3'd0;
            step();
            chk("R6 straps held", {cfg_imdis, cfg_sren, cfg_clksel}, {s[0], s[1], !s[3], !s[2]});
        end

        // R8: show-read with sren latched, memory enabled
        do_reset(4'b0010);
        chk("R8 sren latched", cfg_sren, 1);
        for (int k = 0; k < 4; k++)
            for (int t = 0; t < 5; t++)
                for (int m = 0; m < 2; m++) begin
                    int c;
                    c = (k == 0) ? 2 : (k == 1) ? 1 : (k == 2) ? 4 : 3;
                    cyc_type = 3'(c);
                    tstate = 3'(t);
                    imem_rd = m[0];
                    step();
                    chk("R8 show lanes", show_lane_oe,
                        (m == 1 && (c == 1 || c == 2) && (t == 2 || t == 3)) ? 3 : 0);
                end
        cyc_type = 3'd2;
        tstate = 3'd3;
        imem_rd = 1'b1;
        hold = 1'b1;
        step();
        chk("R8 no show in hold", show_lane_oe, 0);
        hold = 1'b0;
        step();
        chk("R8 show after hold", show_lane_oe, 3);

        do_reset(4'b0011);
        cyc_type = 3'd2;
        tstate = 3'd2;
        imem_rd = 1'b1;
        step();
        chk("R8 memory disabled", show_lane_oe, 0);
        do_reset(4'b0000);
        cyc_type = 3'd2;
        tstate = 3'd2;
        imem_rd = 1'b1;
        step();
        chk("R8 show not latched", show_lane_oe, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule